// File: doc/BRIEF.md
# Debug trap and halt controller

This block sits in the debug unit of a small 8-bit processor and decides when the core must stop. A debugger reaches it through two byte-wide ports. The memory-mapped register window holds two hardware breakpoint addresses, two trap-enable bytes and a read-only record of why the core stopped. The window is decoded by the system at 0x0F80, and this block sees only the low offset. A second, narrow control/status port lets the debugger stop the core, resume it, decide whether a core reset should leave the core stopped, and read whether the core is stopped.

The core reports each instruction boundary with a retire strobe and the word-addressed fetch PC of the next instruction. The same cycle carries qualifiers for a change of flow and for an interrupt vector being entered. A separate strobe reports a core reset, and an external break level comes from a pin. The block turns these into one registered halt request, which rises on the clock edge after the causing event. It also passes the hold-PC enable through to the core.

Top module: `dbg_halt_ctl`

## Requirements
- R1: Breakpoint 0 occupies offsets 0x0–0x3 and breakpoint 1 occupies offsets 0x4–0x7. Each stores byte-address bits 16:1, laid out little-endian: offset+0 holds bits 7:1, offset+1 holds bits 15:8 and offset+2 bit 0 holds bit 16. Address bit 0 and bits 17 and above read 0 and ignore writes.
- R2: At offset 0x8, only bit 2 (single-step), bit 1 (global breakpoint enable) and bit 0 (hold PC) are writable. At offset 0x9, bit 7 (interrupt), bit 6 (change of flow), bit 4 (external break), bit 1 (breakpoint 1) and bit 0 (breakpoint 0) are writable. Bit 5 of offset 0x9 always reads 1, and bits 3:2 read 0.
- R3: At an instruction boundary, breakpoint n halts the core when the fetch PC equals its stored bits 16:1, but only if both its own enable and the global enable are set. The halt request rises on the next clock edge. Breakpoint 0 is recorded at offset 0xD bit 0, and breakpoint 1 at offset 0xD bit 1.
- R4: With single-step enabled, every retired instruction halts the core, recorded at offset 0xD bit 0. After a resume, exactly one more retired instruction runs before the next halt.
- R5: With change-of-flow enabled, a retired instruction that changes the PC halts the core, recorded at offset 0xD bit 6. A retired instruction that does not change the PC does not halt it.
- R6: With interrupt trapping enabled, a boundary that enters an interrupt vector halts the core, recorded at offset 0xD bit 7.
- R7: With external break enabled, a high break input halts a running core one edge later, recorded at offset 0xD bit 4. If the input is still high after a resume, the core halts again one cycle later.
- R8: Writing control address 0x4 with bit 0 set (STOP) halts the core and records offset 0xC bit 6. Writing it with bit 1 set (RUN) releases the halt and clears every cause bit. STOP wins over RUN. Both bits read back 0. Status address 0x5 bit 0 reads 1 while the core is halted.
- R9: A core reset halts the core and leaves only offset 0xC bit 7 set among the causes. This does not happen when control bit 2 (stop-on-reset disable, readable at 0x4 bit 2) is set.
- R10: Offset 0xC bit 2 reads 1 exactly when any other cause bit is set. Writes to offsets 0xC and 0xD are ignored. Offset 0xD bit 5 reads 0.
- R11: While the core is halted, boundary events and the break input change neither the halt nor the causes. When every trap is disabled, boundary events never halt the core.
- R12: The hold-PC output follows offset 0x8 bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the debug block |
| mm_wr | input | 1 | Register window write strobe |
| mm_addr | input | 4 | Register window offset |
| mm_wdata | input | 8 | Register window write data |
| mm_rdata | output | 8 | Register window read data (combinational) |
| cs_wr | input | 1 | Control port write strobe |
| cs_addr | input | 4 | Control port address |
| cs_wdata | input | 3 | Control port write data (implemented bits) |
| cs_rdata | output | 8 | Control port read data |
| ev_valid | input | 1 | Instruction retired at this boundary |
| ev_pc | input | 16 | Word-addressed fetch PC at the boundary |
| ev_cof | input | 1 | Retired instruction changed the PC |
| ev_irq | input | 1 | Interrupt vector entered at this boundary |
| core_rst | input | 1 | Core reset strobe |
| ext_brk | input | 1 | External break level |
| halt | output | 1 | Halt request to the core |
| pc_hold | output | 1 | Hold-PC control to the core |

## Verification
The assertions assume the core raises boundary strobes only while the halt request is low. They also assume that change-of-flow and interrupt qualifiers appear only together with a retire strobe, and that the control port is written only at address 0x4. The stimulus drives qualifiers solely on retire cycles and directs every control write to 0x4. It still presents retire strobes while the core is halted, to confirm that they are ignored. Breakpoint low bytes and fetch PCs are drawn from a small range so that address matches occur often. Resumes are issued often while the core is halted.

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mm_wr,
  input  logic [3:0]  mm_addr,
  input  logic [7:0]  mm_wdata,
  output logic [7:0]  mm_rdata,
  input  logic        cs_wr,
  input  logic [3:0]  cs_addr,
  input  logic [2:0]  cs_wdata,
  output logic [7:0]  cs_rdata,
  input  logic        ev_valid,
  input  logic [15:0] ev_pc,
  input  logic        ev_cof,
  input  logic        ev_irq,
  input  logic        core_rst,
  input  logic        ext_brk,
  output logic        halt,
  output logic        pc_hold
);
  localparam logic [3:0] CTRL_ADDR = 4'h4;
  localparam logic [3:0] STAT_ADDR = 4'h5;

  logic        halted, sor_dis, c_rst, c_req;
  logic [15:0] bp0, bp1;
  logic [2:0]  en_lo;   // {step, global bp, hold pc}
  logic [4:0]  en_hi;   // {irq, cof, ext, bp1, bp0}
  logic [4:0]  c_hi;    // {irq, cof, ext, bp1, bp0/step}
  logic [4:0]  trig;
  logic        stop_req, run_req, rst_halt, bnd, any_cause;

  assign stop_req  = cs_wr && cs_addr == CTRL_ADDR && cs_wdata[0];
  assign run_req   = cs_wr && cs_addr == CTRL_ADDR && cs_wdata[1];
  assign rst_halt  = core_rst && !sor_dis;
  assign bnd       = ev_valid && !halted;
  assign trig[4]   = bnd && en_hi[4] && ev_irq;
  assign trig[3]   = bnd && en_hi[3] && ev_cof;
  assign trig[2]   = !halted && en_hi[2] && ext_brk;
  assign trig[1]   = bnd && en_lo[1] && en_hi[1] && ev_pc == bp1;
  assign trig[0]   = bnd && (en_lo[2] || (en_lo[1] && en_hi[0] && ev_pc == bp0));
  assign any_cause = c_rst || c_req || (|c_hi);
  assign halt      = halted;
  assign pc_hold   = en_lo[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted <= 1'b0; sor_dis <= 1'b0; c_rst <= 1'b0; c_req <= 1'b0;
      bp0 <= '0; bp1 <= '0; en_lo <= '0; en_hi <= '0; c_hi <= '0;
    end else begin
      if (mm_wr) begin
        case (mm_addr)
          4'h0: bp0[6:0]  <= mm_wdata[7:1];
          4'h1: bp0[14:7] <= mm_wdata;
          4'h2: bp0[15]   <= mm_wdata[0];
          4'h4: bp1[6:0]  <= mm_wdata[7:1];
          4'h5: bp1[14:7] <= mm_wdata;
          4'h6: bp1[15]   <= mm_wdata[0];
          4'h8: en_lo     <= mm_wdata[2:0];
          4'h9: en_hi     <= {mm_wdata[7:6], mm_wdata[4], mm_wdata[1:0]};
          default: ;
        endcase
      end
      if (cs_wr && cs_addr == CTRL_ADDR) sor_dis <= cs_wdata[2];
      if (rst_halt) begin
        halted <= 1'b1; c_rst <= 1'b1; c_req <= 1'b0; c_hi <= '0;
      end else if (stop_req) begin
        halted <= 1'b1; c_req <= 1'b1; c_hi <= c_hi | trig;
      end else if (|trig) begin
        halted <= 1'b1; c_hi <= c_hi | trig;
      end else if (run_req) begin
        halted <= 1'b0; c_rst <= 1'b0; c_req <= 1'b0; c_hi <= '0;
      end
    end
  end

  always_comb begin
    case (mm_addr)
      4'h0: mm_rdata = {bp0[6:0], 1'b0};
      4'h1: mm_rdata = bp0[14:7];
      4'h2: mm_rdata = {7'b0, bp0[15]};
      4'h4: mm_rdata = {bp1[6:0], 1'b0};
      4'h5: mm_rdata = bp1[14:7];
      4'h6: mm_rdata = {7'b0, bp1[15]};
      4'h8: mm_rdata = {5'b0, en_lo};
      4'h9: mm_rdata = {en_hi[4:3], 1'b1, en_hi[2], 2'b0, en_hi[1:0]};
      4'hC: mm_rdata = {c_rst, c_req, 3'b0, any_cause, 2'b0};
      4'hD: mm_rdata = {c_hi[4:3], 1'b0, c_hi[2], 2'b0, c_hi[1:0]};
      default: mm_rdata = 8'h00;
    endcase
  end

  always_comb begin
    case (cs_addr)
      CTRL_ADDR: cs_rdata = {5'b0, sor_dis, 2'b0};
      STAT_ADDR: cs_rdata = {7'b0, halted};
      default:   cs_rdata = 8'h00;
    endcase
  end

  assert_step_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && ev_valid && en_lo[2]) |=> halted);
  assert_reset_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst && !sor_dis) |=> (halted && c_rst));
  assert_run_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && run_req && !stop_req && !core_rst) |=> (!halted && !any_cause));
  assert_halt_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> any_cause);
  assert_frozen_while_halted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !core_rst && !stop_req && !run_req) |=> (halted && $stable(c_hi)));
  assert_no_spurious_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !core_rst && !stop_req && en_lo[2:1] == 2'b00 && en_hi == 5'b0) |=> !halted);
endmodule

// File: tb/dbg_halt_ctl_test.sv
`timescale 1ns/1ps
module dbg_halt_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mm_wr = 0, cs_wr = 0, ev_valid = 0, ev_cof = 0, ev_irq = 0, core_rst = 0, ext_brk = 0;
  logic [3:0] mm_addr = 0, cs_addr = 4'h5;
  logic [7:0] mm_wdata = 0;
  logic [2:0] cs_wdata = 0;
  logic [15:0] ev_pc = 0;
  logic [7:0] mm_rdata, cs_rdata;
  logic halt, pc_hold;

  always #2 clk = ~clk;

  dbg_halt_ctl uut (.clk(clk), .rst_n(rst_n), .mm_wr(mm_wr), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .mm_rdata(mm_rdata), .cs_wr(cs_wr), .cs_addr(cs_addr), .cs_wdata(cs_wdata), .cs_rdata(cs_rdata),
    .ev_valid(ev_valid), .ev_pc(ev_pc), .ev_cof(ev_cof), .ev_irq(ev_irq), .core_rst(core_rst),
    .ext_brk(ext_brk), .halt(halt), .pc_hold(pc_hold));

  int nvec = 0, nfail = 0;
  bit finished = 0;

  logic m_halt = 0, m_crst = 0, m_creq = 0, m_sor = 0;
  logic [7:0] m_c1 = 0, m_e9 = 8'h20;
  logic [2:0] m_e8 = 0;
  logic [15:0] m_bp0 = 0, m_bp1 = 0;

  function automatic logic [7:0] exp_c0();
    return {m_crst, m_creq, 3'b0, (m_crst | m_creq | (|m_c1)), 2'b0};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_mm(input logic [3:0] a, output logic [7:0] d);
    mm_addr = a; #0.1; d = mm_rdata;
  endtask

  task automatic rd_cs(input logic [3:0] a, output logic [7:0] d);
    cs_addr = a; #0.1; d = cs_rdata;
  endtask

  task automatic model(input bit mw, input logic [3:0] ma, input logic [7:0] md, input bit cw,
                       input logic [2:0] cd, input bit v, input logic [15:0] pc, input bit cof,
                       input bit irq, input bit crst, input bit eb);
    logic [7:0] t = 0;
    if (!m_halt) begin
      if (v) begin
        if (m_e8[2] || (m_e8[1] && m_e9[0] && pc == m_bp0)) t[0] = 1;
        if (m_e8[1] && m_e9[1] && pc == m_bp1) t[1] = 1;
        if (m_e9[6] && cof) t[6] = 1;
        if (m_e9[7] && irq) t[7] = 1;
      end
      if (m_e9[4] && eb) t[4] = 1;
    end
    if (crst && !m_sor) begin m_halt = 1; m_crst = 1; m_creq = 0; m_c1 = 0; end
    else if (cw && cd[0]) begin m_halt = 1; m_creq = 1; m_c1 |= t; end
    else if (t != 0) begin m_halt = 1; m_c1 |= t; end
    else if (cw && cd[1]) begin m_halt = 0; m_crst = 0; m_creq = 0; m_c1 = 0; end
    if (cw) m_sor = cd[2];
    if (mw) begin
      case (ma)
        4'h0: m_bp0[6:0] = md[7:1];
        4'h1: m_bp0[14:7] = md;
        4'h2: m_bp0[15] = md[0];
        4'h4: m_bp1[6:0] = md[7:1];
        4'h5: m_bp1[14:7] = md;
        4'h6: m_bp1[15] = md[0];
        4'h8: m_e8 = md[2:0];
        4'h9: m_e9 = (md & 8'hD3) | 8'h20;
        default: ;
      endcase
    end
  endtask

  task automatic step(input bit mw, input logic [3:0] ma, input logic [7:0] md, input bit cw,
                      input logic [2:0] cd, input bit v, input logic [15:0] pc, input bit cof,
                      input bit irq, input bit crst, input bit eb);
    mm_wr = mw; mm_addr = ma; mm_wdata = md; cs_wr = cw; cs_addr = cw ? 4'h4 : 4'h5; cs_wdata = cd;
    ev_valid = v; ev_pc = pc; ev_cof = cof; ev_irq = irq; core_rst = crst; ext_brk = eb;
    model(mw, ma, md, cw, cd, v, pc, cof, irq, crst, eb);
    @(posedge clk); #1;
    mm_wr = 0; cs_wr = 0; ev_valid = 0; ev_cof = 0; ev_irq = 0; core_rst = 0;
    chk("R11 halt vs model", {7'b0, halt}, {7'b0, m_halt});
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, ext_brk); endtask
  task automatic mmw(input logic [3:0] a, input logic [7:0] d); step(1, a, d, 0, 0, 0, 0, 0, 0, 0, ext_brk); endtask
  task automatic csw(input logic [2:0] d); step(0, 0, 0, 1, d, 0, 0, 0, 0, 0, ext_brk); endtask
  task automatic ev(input logic [15:0] pc, input bit cof, input bit irq); step(0, 0, 0, 0, 0, 1, pc, cof, irq, 0, ext_brk); endtask

  initial begin
    #(190000 * 4);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // reset state
    chk("R8 halt after reset", {7'b0, halt}, 8'h00);
    rd_mm(4'h9, d); chk("R2 reset 0x9", d, 8'h20);
    rd_mm(4'hC, d); chk("R10 reset 0xC", d, 8'h00);
    rd_cs(4'h5, d); chk("R8 reset status", d, 8'h00);
    // R1 breakpoint field width
    for (int i = 0; i < 4; i++) mmw(i[3:0], 8'hFF);
    for (int i = 4; i < 8; i++) mmw(i[3:0], 8'hFF);
    rd_mm(4'h0, d); chk("R1 bp0 byte0", d, 8'hFE);
    rd_mm(4'h1, d); chk("R1 bp0 byte1", d, 8'hFF);
    rd_mm(4'h2, d); chk("R1 bp0 byte2", d, 8'h01);
    rd_mm(4'h3, d); chk("R1 bp0 byte3", d, 8'h00);
    rd_mm(4'h6, d); chk("R1 bp1 byte2", d, 8'h01);
    rd_mm(4'h7, d); chk("R1 bp1 byte3", d, 8'h00);
    mmw(4'h0, 8'h40); mmw(4'h1, 8'h00); mmw(4'h2, 8'h00);
    rd_mm(4'h0, d); chk("R1 bp0 low write", d, 8'h40);
    // R2 enable masks, R12 hold pc
    mmw(4'h8, 8'hFF); rd_mm(4'h8, d); chk("R2 0x8 mask", d, 8'h07);
    chk("R12 hold pc on", {7'b0, pc_hold}, 8'h01);
    mmw(4'h9, 8'hFF); rd_mm(4'h9, d); chk("R2 0x9 mask", d, 8'hF3);
    mmw(4'h9, 8'h00); rd_mm(4'h9, d); chk("R2 sw bp bit stuck", d, 8'h20);
    mmw(4'h8, 8'h00); chk("R12 hold pc off", {7'b0, pc_hold}, 8'h00);
    // R9 core reset
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R9 reset halts", {7'b0, halt}, 8'h01);
    rd_mm(4'hC, d); chk("R9 reset cause", d, 8'h84);
    mmw(4'hC, 8'h00); rd_mm(4'hC, d); chk("R10 cause ignores write", d, 8'h84);
    rd_cs(4'h5, d); chk("R8 status stopped", d, 8'h01);
    // R8 run/stop
    csw(3'b010);
    chk("R8 run releases", {7'b0, halt}, 8'h00);
    rd_mm(4'hC, d); chk("R8 run clears 0xC", d, 8'h00);
    rd_cs(4'h4, d); chk("R8 run self clears", d, 8'h00);
    csw(3'b001); rd_mm(4'hC, d); chk("R8 stop cause", d, 8'h44);
    csw(3'b010); csw(3'b011); chk("R8 stop beats run", {7'b0, halt}, 8'h01);
    csw(3'b010);
    // R9 stop-on-reset disable
    csw(3'b100); rd_cs(4'h4, d); chk("R9 sor readback", d, 8'h04);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R9 sor disables halt", {7'b0, halt}, 8'h00);
    csw(3'b000);
    // R3 breakpoints need both enables
    mmw(4'h9, 8'h01); ev(16'h0020, 0, 0);
    chk("R3 no global enable", {7'b0, halt}, 8'h00);
    mmw(4'h8, 8'h02); ev(16'h0021, 0, 0);
    chk("R3 no address match", {7'b0, halt}, 8'h00);
    ev(16'h0020, 0, 0);
    chk("R3 bp0 halts", {7'b0, halt}, 8'h01);
    rd_mm(4'hD, d); chk("R3 bp0 cause", d, 8'h01);
    csw(3'b010);
    mmw(4'h4, 8'h60); mmw(4'h5, 8'h00); mmw(4'h6, 8'h00); mmw(4'h9, 8'h02);
    ev(16'h0020, 0, 0); chk("R3 bp0 disabled", {7'b0, halt}, 8'h00);
    ev(16'h0030, 0, 0);
    rd_mm(4'hD, d); chk("R3 bp1 cause", d, 8'h02);
    csw(3'b010); mmw(4'h8, 8'h00); mmw(4'h9, 8'h00);
    // R4 single step
    mmw(4'h8, 8'h04); ev(16'h0100, 0, 0);
    rd_mm(4'hD, d); chk("R4 step cause", d, 8'h01);
    csw(3'b010); idle();
    chk("R4 no step without retire", {7'b0, halt}, 8'h00);
    ev(16'h0101, 0, 0);
    chk("R4 one instruction then halt", {7'b0, halt}, 8'h01);
    csw(3'b010); mmw(4'h8, 8'h00);
    // R5 change of flow
    mmw(4'h9, 8'h40); ev(16'h0005, 0, 0);
    chk("R5 straight line no halt", {7'b0, halt}, 8'h00);
    ev(16'h0040, 1, 0); rd_mm(4'hD, d); chk("R5 cof cause", d, 8'h40);
    csw(3'b010);
    // R6 interrupt
    mmw(4'h9, 8'h80); ev(16'h0002, 0, 1);
    rd_mm(4'hD, d); chk("R6 irq cause", d, 8'h80);
    csw(3'b010);
    // R7 external break
    mmw(4'h9, 8'h10); ext_brk = 1; idle();
    rd_mm(4'hD, d); chk("R7 ext cause", d, 8'h10);
    csw(3'b010); chk("R7 released for a cycle", {7'b0, halt}, 8'h00);
    idle(); chk("R7 re-halts while high", {7'b0, halt}, 8'h01);
    ext_brk = 0; csw(3'b010); idle();
    chk("R7 stays running when low", {7'b0, halt}, 8'h00);
    // R11 events ignored while halted
    csw(3'b001); mmw(4'h8, 8'h04); ev(16'h0000, 1, 1);
    rd_mm(4'hD, d); chk("R11 halted ignores events", d, 8'h00);
    rd_mm(4'hC, d); chk("R11 halted cause kept", d, 8'h44);
    csw(3'b010); mmw(4'h8, 8'h00); mmw(4'h9, 8'h00);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 100;
      if (r < 8) begin
        logic [3:0] a = 4'($urandom % 10);
        logic [7:0] dd = (a == 1 || a == 2 || a == 5 || a == 6) ? 8'h00 : 8'($urandom % 16);
        if (a == 8 || a == 9) dd = 8'($urandom);
        step(1, a, dd, 0, 0, 0, 0, 0, 0, 0, ext_brk);
      end else if (r < 11 || (m_halt && r < 40)) begin
        logic [2:0] c = (r < 11) ? 3'($urandom) : {1'b0, 2'b10};
        step(0, 0, 0, 1, c, 0, 0, 0, 0, 0, ext_brk);
      end else if (r < 13) begin
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, ext_brk);
      end else begin
        bit v = ($urandom % 10) < 6;
        if (($urandom % 100) < 5) ext_brk = ~ext_brk;
        step(0, 0, 0, 0, 0, v, 16'($urandom % 8), v && ($urandom % 5 == 0),
             v && ($urandom % 10 == 0), 0, ext_brk);
      end
      rd_mm(4'hC, d); chk("R10 random 0xC", d, exp_c0());
      rd_mm(4'hD, d); chk("R3-R7 random 0xD", d, m_c1);
      rd_cs(4'h5, d); chk("R8 random status", d, {7'b0, m_halt});
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule